// File: doc/BRIEF.md
# Three-Wire Serial Register Port

This block is the slave end of a three-wire serial control port. The host pulls an active-low select line, toggles a serial clock and moves bits over one shared data line. Each transfer opens with an 8-bit header. Its most significant bit gives the direction and its lower seven bits give a register address. A data byte follows the header. On a write, the host drives that byte. On a read, the block drives it back on the same line. Both bytes go most significant bit first.

Behind the port sits a bank of 8-bit registers. The lowest addresses hold read/write control registers, and their contents appear on a flat output bus. A second window holds read-only status bytes taken from input pins. The serial pins are oversampled by the system clock through a short synchronizer. The serial clock must therefore run several times slower than the system clock.

The data line is modelled as three signals: the sampled input, the driven value and an output enable. A pad cell outside the block combines them.

Top module: `ser3w_regport`

## Requirements
- R1: While the select input is high, serial clock edges and data values have no effect: no register changes and the data line stays released.
- R2: The first header bit sampled on a rising serial clock edge is the direction (0 = write, 1 = read). The next seven bits, most significant first, are the register address, and they pick which register a transfer touches.
- R3: On a write, the eight bits after the header are sampled on rising serial clock edges, most significant first. The addressed control register takes the whole byte once the eighth data bit is sampled.
- R4: On a read, the block starts driving the data line on the first falling serial clock edge after the last header bit, with the register's bit 7. It moves to the next lower bit on each following falling edge, and it releases the line on the falling edge after the eighth data bit.
- R5: Control registers sit at addresses 0 to NUM_CTRL-1 (0 to 11 by default). Each reads back the last value written to it, and each appears on the control output bus at bits [8*a+7:8*a].
- R6: Status registers sit at addresses STATUS_BASE to STATUS_BASE+NUM_STATUS-1 (12 to 15 by default). A read returns status input byte (a-STATUS_BASE), and a write to them changes nothing.
- R7: An address that maps to neither window reads as 0x00, and a write to it changes nothing.
- R8: After reset every control register is 0x00 and the data line is released. This includes bit 6 of the mode register at address 9, which selects pin-strapped operation.
- R9: Raising the select line before a transfer completes aborts it: the line is released, no register changes, and the next transfer starts again at its header.
- R10: Serial clock edges after the sixteenth bit of a transfer are ignored until the select line rises.
- R11: The block never drives the data line during a write transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial pins |
| rstN | input | 1 | Active-low asynchronous reset |
| selN | input | 1 | Active-low transfer select from the host |
| sclk | input | 1 | Serial clock from the host |
| sdaIn | input | 1 | Value seen on the shared data line |
| sdaOut | output | 1 | Value the block drives onto the data line |
| sdaOe | output | 1 | High while the block drives the data line |
| statusIn | input | NUM_STATUS*DATA_W | Read-only status bytes, byte i at bits [8*i+7:8*i] |
| ctrlOut | output | NUM_CTRL*DATA_W | Control register contents, register a at bits [8*a+7:8*a] |

## Verification
The embedded properties are checked on every cycle:
- the bit counter never runs past sixteen;
- a released select clears the counter;
- at most one shift or load strobe fires per cycle;
- the line is never driven while the header marks a write;
- a write strobe aimed outside the control window leaves the control bus unchanged.

Some behaviour only the bench scenarios can show, because it depends on the host's bit stream. This covers:
- correct placement of written bytes;
- the exact falling edge on which read data appears and is released;
- status and unmapped readback values;
- the effect of aborted transfers;
- the effect of surplus clocks.

// File: rtl/ser3w_pkg.sv
package ser3w_pkg;
  // Strobes from the sequencer to the register datapath.
  typedef struct packed {
    logic shiftAddr;    // take one header bit
    logic shiftData;    // take one write-data bit
    logic commitWrite;  // last write bit present: update the register
    logic loadOut;      // load read value and start driving
    logic shiftOut;     // present the next read bit
    logic relOut;       // stop driving the data line
  } strobe_t;
endpackage

// File: rtl/ser3w_sync.sv
module ser3w_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic selNAsync,
  input  logic sclkAsync,
  input  logic sdaAsync,
  output logic active,
  output logic sclkRise,
  output logic sclkFall,
  output logic sdaBit
);
  localparam int LAST = STAGES - 1;
  // bit 2: select, bit 1: serial clock, bit 0: data
  logic [2:0] pipe [STAGES];
  logic sclkPrev;

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) pipe[s] <= 3'b100;
          else       pipe[s] <= {selNAsync, sclkAsync, sdaAsync};
      end else begin : g_rest
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) pipe[s] <= 3'b100;
          else       pipe[s] <= pipe[s-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) sclkPrev <= 1'b0;
    else       sclkPrev <= pipe[LAST][1];

  assign active   = ~pipe[LAST][2];
  assign sclkRise =  pipe[LAST][1] & ~sclkPrev;
  assign sclkFall = ~pipe[LAST][1] &  sclkPrev;
  assign sdaBit   =  pipe[LAST][0];
endmodule

// File: rtl/ser3w_ctrl.sv
module ser3w_ctrl
  import ser3w_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 7
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    active,
  input  logic    sclkRise,
  input  logic    sclkFall,
  input  logic    dirRead,
  output strobe_t strb
);
  localparam int HDR   = 1 + ADDR_W;
  localparam int TOTAL = HDR + DATA_W;
  localparam int CW    = $clog2(TOTAL + 1);
  localparam logic [CW-1:0] HDR_C   = CW'(HDR);
  localparam logic [CW-1:0] TOTAL_C = CW'(TOTAL);
  localparam logic [CW-1:0] LASTW_C = CW'(TOTAL - 1);

  logic [CW-1:0] bitCnt;

  always_ff @(posedge clk or negedge rstN)
    if (!rstN)                             bitCnt <= '0;
    else if (!active)                      bitCnt <= '0;
    else if (sclkRise && bitCnt < TOTAL_C) bitCnt <= bitCnt + 1'b1;

  always_comb begin
    strb = '0;
    if (!active) begin
      strb.relOut = 1'b1;
    end else begin
      if (sclkRise) begin
        if (bitCnt < HDR_C) begin
          strb.shiftAddr = 1'b1;
        end else if (bitCnt < TOTAL_C && !dirRead) begin
          strb.shiftData   = 1'b1;
          strb.commitWrite = (bitCnt == LASTW_C);
        end
      end
      if (sclkFall && dirRead) begin
        if (bitCnt == HDR_C)        strb.loadOut  = 1'b1;
        else if (bitCnt > HDR_C && bitCnt < TOTAL_C)
                                    strb.shiftOut = 1'b1;
        else if (bitCnt == TOTAL_C) strb.relOut   = 1'b1;
      end
    end
  end

  assert_abort_clears_R9: assert property (@(posedge clk) disable iff (!rstN)
    !active |=> bitCnt == '0);
  assert_count_bound_R10: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= TOTAL_C);
  assert_one_strobe_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.shiftAddr, strb.shiftData, strb.loadOut, strb.shiftOut}));
endmodule

// File: rtl/ser3w_regfile.sv
module ser3w_regfile
  import ser3w_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 7,
  parameter int NUM_CTRL    = 12,
  parameter int STATUS_BASE = 12,
  parameter int NUM_STATUS  = 4
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  strobe_t                      strb,
  input  logic                         sdaBit,
  input  logic [NUM_STATUS*DATA_W-1:0] statusIn,
  output logic                         dirRead,
  output logic                         sdaOut,
  output logic                         sdaOe,
  output logic [NUM_CTRL*DATA_W-1:0]   ctrlOut
);
  logic [ADDR_W:0]   addrSh;
  logic [DATA_W-1:0] dataSh;
  logic [DATA_W-1:0] outSh;
  logic [DATA_W-1:0] newByte;
  logic [DATA_W-1:0] readVal;
  logic [ADDR_W-1:0] regAddr;
  logic [DATA_W-1:0] ctrlReg [NUM_CTRL];

  assign dirRead = addrSh[ADDR_W];
  assign regAddr = addrSh[ADDR_W-1:0];
  assign newByte = {dataSh[DATA_W-2:0], sdaBit};

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      addrSh <= '0;
      dataSh <= '0;
    end else begin
      if (strb.shiftAddr) addrSh <= {addrSh[ADDR_W-1:0], sdaBit};
      if (strb.shiftData) dataSh <= newByte;
    end

  genvar r;
  generate
    for (r = 0; r < NUM_CTRL; r++) begin : g_ctrl
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) ctrlReg[r] <= '0;
        else if (strb.commitWrite && regAddr == ADDR_W'(r)) ctrlReg[r] <= newByte;
      assign ctrlOut[r*DATA_W +: DATA_W] = ctrlReg[r];
    end
  endgenerate

  always_comb begin
    readVal = '0;
    for (int i = 0; i < NUM_CTRL; i++)
      if (regAddr == ADDR_W'(i)) readVal = ctrlReg[i];
    for (int i = 0; i < NUM_STATUS; i++)
      if (regAddr == ADDR_W'(STATUS_BASE + i)) readVal = statusIn[i*DATA_W +: DATA_W];
  end

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      outSh <= '0;
      sdaOe <= 1'b0;
    end else if (strb.relOut) begin
      sdaOe <= 1'b0;
    end else if (strb.loadOut) begin
      outSh <= readVal;
      sdaOe <= 1'b1;
    end else if (strb.shiftOut) begin
      outSh <= {outSh[DATA_W-2:0], 1'b0};
    end

  assign sdaOut = outSh[DATA_W-1];

  assert_no_drive_on_write_R11: assert property (@(posedge clk) disable iff (!rstN)
    sdaOe |-> dirRead);
  assert_ro_write_ignored_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.commitWrite && int'(regAddr) >= NUM_CTRL) |=> ctrlOut == $past(ctrlOut));
endmodule

// File: rtl/ser3w_regport.sv
module ser3w_regport
  import ser3w_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 7,
  parameter int NUM_CTRL    = 12,
  parameter int STATUS_BASE = 12,
  parameter int NUM_STATUS  = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         selN,
  input  logic                         sclk,
  input  logic                         sdaIn,
  output logic                         sdaOut,
  output logic                         sdaOe,
  input  logic [NUM_STATUS*DATA_W-1:0] statusIn,
  output logic [NUM_CTRL*DATA_W-1:0]   ctrlOut
);
  logic    active, sclkRise, sclkFall, sdaBit, dirRead;
  strobe_t strb;

  ser3w_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .selNAsync(selN), .sclkAsync(sclk), .sdaAsync(sdaIn),
    .active(active), .sclkRise(sclkRise), .sclkFall(sclkFall), .sdaBit(sdaBit));

  ser3w_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .active(active), .sclkRise(sclkRise),
    .sclkFall(sclkFall), .dirRead(dirRead), .strb(strb));

  ser3w_regfile #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_CTRL(NUM_CTRL),
                  .STATUS_BASE(STATUS_BASE), .NUM_STATUS(NUM_STATUS)) u_regs (
    .clk(clk), .rstN(rstN), .strb(strb), .sdaBit(sdaBit), .statusIn(statusIn),
    .dirRead(dirRead), .sdaOut(sdaOut), .sdaOe(sdaOe), .ctrlOut(ctrlOut));
endmodule

// File: tb/ser3w_regport_tb.sv
module ser3w_regport_tb;
  localparam int CLK_P = 10;
  localparam int HALF  = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        selN = 1'b1, sclk = 1'b0, sdaIn = 1'b0;
  logic        sdaOut, sdaOe;
  logic [31:0] statusIn = 32'h81_3C_FF_00;
  logic [95:0] ctrlOut;

  int errors = 0, checks = 0;
  logic [7:0] expQ[$], gotQ[$];
  string      tagQ[$];

  ser3w_regport u_dut (.clk(clk), .rstN(rstN), .selN(selN), .sclk(sclk), .sdaIn(sdaIn),
    .sdaOut(sdaOut), .sdaOe(sdaOe), .statusIn(statusIn), .ctrlOut(ctrlOut));

  always #(CLK_P/2) clk = ~clk;

  task automatic check(string tag, logic [95:0] act, logic [95:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic waitH();
    repeat (HALF) @(negedge clk);
  endtask

  // Send one bit: set data, rise, fall. R11: line must stay released on writes.
  task automatic sendBit(logic b, bit chkRel);
    sdaIn = b;
    waitH();
    if (chkRel) check("R11 released during write", sdaOe, 0);
    sclk = 1'b1; waitH(); sclk = 1'b0;
  endtask

  task automatic sendHeader(logic rd, logic [6:0] a, bit chkRel);
    selN = 1'b0; waitH();
    sendBit(rd, chkRel);
    for (int i = 6; i >= 0; i--) sendBit(a[i], chkRel);
  endtask

  task automatic endXfer();
    waitH(); selN = 1'b1; waitH();
  endtask

  task automatic writeReg(logic [6:0] a, logic [7:0] v);
    sendHeader(1'b0, a, 1'b1);
    for (int i = 7; i >= 0; i--) sendBit(v[i], 1'b1);
    endXfer();
  endtask

  // Driver: push expectation, then shift the byte out of the design.
  task automatic readReg(logic [6:0] a, logic [7:0] exp, string tag);
    logic [7:0] got;
    expQ.push_back(exp); tagQ.push_back(tag);
    sendHeader(1'b1, a, 1'b0);
    for (int i = 7; i >= 0; i--) begin
      waitH();
      check("R4 driven during read data", sdaOe, 1);
      got[i] = sdaOut;
      sclk = 1'b1; waitH(); sclk = 1'b0;
    end
    waitH();
    check("R4 released after eighth bit", sdaOe, 0);
    gotQ.push_back(got);
    selN = 1'b1; waitH();
  endtask

  // Monitor: compare results in order against the expected queue.
  always @(negedge clk)
    if (gotQ.size() > 0 && expQ.size() > 0)
      check(tagQ.pop_front(), 96'(gotQ.pop_front()), 96'(expQ.pop_front()));

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    logic [95:0] snap;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    // R8 reset state
    check("R8 control bus reset", ctrlOut, 0);
    check("R8 mode reg bit6", ctrlOut[9*8+6], 0);
    check("R8 line released", sdaOe, 0);
    readReg(7'd9, 8'h00, "R8 mode register reads 0");

    // R3 / R5 basic write and readback
    writeReg(7'd0, 8'h5A);
    check("R3 byte lands on bus", ctrlOut[7:0], 8'h5A);
    readReg(7'd0, 8'h5A, "R5 readback addr 0");
    writeReg(7'd11, 8'hA5);
    check("R5 last control reg on bus", ctrlOut[88 +: 8], 8'hA5);
    readReg(7'd11, 8'hA5, "R5 readback addr 11");

    // R2 address selects the right register
    writeReg(7'd6, 8'h01);
    writeReg(7'd7, 8'h80);
    check("R2 addr 6 placement", ctrlOut[48 +: 8], 8'h01);
    check("R2 addr 7 placement", ctrlOut[56 +: 8], 8'h80);
    check("R2 addr 0 untouched", ctrlOut[7:0], 8'h5A);
    readReg(7'd7, 8'h80, "R2 read addr 7");

    // R6 status window
    readReg(7'd12, 8'h00, "R6 status byte 0");
    readReg(7'd13, 8'hFF, "R6 status byte 1");
    readReg(7'd15, 8'h81, "R6 status byte 3");
    snap = ctrlOut;
    writeReg(7'd13, 8'h11);
    check("R6 write to status ignored", ctrlOut, snap);
    readReg(7'd13, 8'hFF, "R6 status unchanged after write");

    // R7 unmapped
    readReg(7'h50, 8'h00, "R7 unmapped reads 0");
    writeReg(7'h50, 8'h77);
    check("R7 write unmapped ignored", ctrlOut, snap);

    // R1 clocks while deselected
    for (int i = 0; i < 20; i++) begin
      sdaIn = i[0]; waitH(); sclk = 1'b1; waitH(); sclk = 1'b0;
    end
    waitH();
    check("R1 no effect while deselected", ctrlOut, snap);
    check("R1 line released while deselected", sdaOe, 0);

    // R9 abort mid-write then fresh transfer
    sendHeader(1'b0, 7'd2, 1'b1);
    for (int i = 0; i < 4; i++) sendBit(1'b1, 1'b1);
    endXfer();
    check("R9 aborted write changes nothing", ctrlOut, snap);
    writeReg(7'd2, 8'h33);
    check("R9 fresh write after abort", ctrlOut[16 +: 8], 8'h33);
    // R9 abort mid-read
    sendHeader(1'b1, 7'd0, 1'b0);
    for (int i = 0; i < 3; i++) begin
      waitH(); sclk = 1'b1; waitH(); sclk = 1'b0;
    end
    waitH();
    check("R9 driving before abort", sdaOe, 1);
    selN = 1'b1; waitH();
    check("R9 released on abort", sdaOe, 0);
    readReg(7'd2, 8'h33, "R9 read after aborted read");

    // R10 surplus clocks ignored
    sendHeader(1'b0, 7'd3, 1'b1);
    for (int i = 7; i >= 0; i--) sendBit(i < 4, 1'b1);
    for (int i = 0; i < 5; i++) sendBit(1'b1, 1'b1);
    endXfer();
    check("R10 surplus clocks ignored", ctrlOut[24 +: 8], 8'h0F);
    readReg(7'd3, 8'h0F, "R10 readback");

    repeat (5) @(negedge clk);
    while (gotQ.size() > 0) @(negedge clk);
    finishRun();
  end
endmodule